// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. The caller presents a virtual address, a read/write flag and the root table base. The walker issues one read for the first-level entry, which selects the leaf table. It then issues one read for the leaf entry and returns the physical page number joined with the untouched page offset. Any missing entry, and any write to a page that is not writable, ends the walk with a fault code and no translation. Nothing is cached and no entry is ever written back.

The virtual address is split into three fields. Bits 31:22 index the root table, bits 21:12 index the leaf table, and bits 11:0 are the byte offset. Each entry is four bytes, so a table of 1024 entries fills one 4 KB page. An entry holds the physical page number in bits 31:12, a valid flag in bit 0 and a writable flag in bit 1. All other entry bits are ignored.

The controller has six states:
- `ST_IDLE`: waits for a request.
- `ST_L1_REQ` and `ST_L1_WAIT`: present the root-entry read, then wait for its response.
- `ST_L2_REQ` and `ST_L2_WAIT`: do the same for the leaf entry.
- `ST_DONE`: a single cycle that reports the result.

The transitions are:
- accept: `ST_IDLE` to `ST_L1_REQ`, when a request arrives.
- issue: each REQ state to its WAIT state, when the read handshake completes.
- descend: `ST_L1_WAIT` to `ST_L2_REQ`, on a valid root entry.
- abort: `ST_L1_WAIT` to `ST_DONE`, on an invalid root entry.
- finish: `ST_L2_WAIT` to `ST_DONE`.
- release: `ST_DONE` to `ST_IDLE`.

Top module: `ptw_walker`

## Requirements
- R1: After reset `busy`, `done`, `fault` and `mem_req_valid` are low.
- R2: A request is taken only in the idle state. `busy` is high from the cycle after acceptance up to and including the `done` cycle, and low after it. A `req_valid` seen while busy is ignored.
- R3: The first read goes to `req_ptbr + vaddr[31:22]*4`.
- R4: The second read goes to `{root_entry[31:12], 12'h000} + vaddr[21:12]*4`.
- R5: On success, `paddr = {leaf_entry[31:12], vaddr[11:0]}` and `fault_code` is 0. Exactly two reads are issued.
- R6: A root entry with bit 0 clear ends the walk with `fault_code` 1 after a single read.
- R7: A leaf entry with bit 0 clear ends the walk with `fault_code` 2. This check takes priority over the write check.
- R8: A write whose valid leaf entry has bit 1 clear ends with `fault_code` 3. A read of the same page succeeds.
- R9: `done` is a one-cycle pulse for every request. `fault`, `fault_code` and `paddr` are zero outside `done`. `paddr` is zero whenever `fault` is high.
- R10: The read request keeps `mem_req_valid` high and `mem_req_addr` stable until `mem_req_ready`. The walker waits any number of cycles for `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_ptbr | input | 32 | Root table base address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Walk ended in a fault (valid with done) |
| fault_code | output | 2 | 0 none, 1 root invalid, 2 leaf invalid, 3 write to read-only page |
| paddr | output | 32 | Translated address (valid with done and no fault) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Entry byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry contents |

## Verification
The assertions watch several properties on every cycle:
- `done` lasts one cycle and drops `busy` after it.
- The result outputs stay quiet between walks, and a fault never carries an address.
- A stalled read request holds its address.
- An accepted request raises `busy`.

Which entries are read, in what order, and the fault code chosen for each entry pattern can only be shown by the bench's scenarios, which model memory from a known table. The same holds for the index extremes, for memory stalls and late responses, and for requests that arrive mid-walk and must be ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE       = 2'd0,
        FLT_L1_INVALID = 2'd1,
        FLT_L2_INVALID = 2'd2,
        FLT_WRITE_PROT = 2'd3
    } fault_code_t;

endpackage

// File: rtl/ptw_entry_addr.sv
// Byte address of one table entry: table base plus scaled index.
module ptw_entry_addr #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned IDX_W       = 10,
    parameter int unsigned ENTRY_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned SCALE_SH = $clog2(ENTRY_BYTES);

    assign addr = base + (ADDR_W'(idx) << SCALE_SH);
endmodule

// File: rtl/ptw_pte_decode.sv
// Classifies one returned entry into a fault code and extracts its page number.
module ptw_pte_decode
    import ptw_pkg::*;
#(
    parameter int unsigned PTE_W     = 32,
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned VALID_BIT = 0,
    parameter int unsigned WRITE_BIT = 1
) (
    input  logic [PTE_W-1:0]       pte,
    input  logic                   is_leaf,
    input  logic                   want_write,
    output logic [PTE_W-OFF_W-1:0] ppn,
    output fault_code_t            code
);
    logic unused_rsvd;

    assign ppn         = pte[PTE_W-1:OFF_W];
    assign unused_rsvd = ^pte[OFF_W-1:WRITE_BIT+1];

    always_comb begin
        if (!pte[VALID_BIT]) begin
            code = is_leaf ? FLT_L2_INVALID : FLT_L1_INVALID;
        end else if (is_leaf && want_write && !pte[WRITE_BIT]) begin
            code = FLT_WRITE_PROT;
        end else begin
            code = FLT_NONE;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned L1_W      = 10,
    parameter int unsigned L2_W      = 10,
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned PTE_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    input  logic [VA_W-1:0] req_ptbr,
    output logic            busy,
    output logic            done,
    output logic            fault,
    output logic [1:0]      fault_code,
    output logic [VA_W-1:0] paddr,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [VA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [VA_W-1:0] mem_rsp_data
);
    localparam int unsigned PPN_W = VA_W - OFF_W;
    localparam int unsigned IDX_W = (L1_W > L2_W) ? L1_W : L2_W;

    walk_state_t state, state_nx;
    logic [VA_W-1:0]  va_q;
    logic             wr_q;
    logic [VA_W-1:0]  base_q;
    fault_code_t      code_q;
    logic [PPN_W-1:0] ppn_q;

    logic [IDX_W-1:0] cur_idx;
    logic             in_root;
    logic             is_leaf;
    logic [PPN_W-1:0] dec_ppn;
    fault_code_t      dec_code;

    assign in_root = (state == ST_L1_REQ) || (state == ST_L1_WAIT);
    assign is_leaf = (state == ST_L2_WAIT);
    assign cur_idx = in_root ? IDX_W'(va_q[VA_W-1 -: L1_W])
                             : IDX_W'(va_q[OFF_W +: L2_W]);

    ptw_entry_addr #(
        .ADDR_W      (VA_W),
        .IDX_W       (IDX_W),
        .ENTRY_BYTES (PTE_BYTES)
    ) u_addr (
        .base (base_q),
        .idx  (cur_idx),
        .addr (mem_req_addr)
    );

    ptw_pte_decode #(
        .PTE_W (VA_W),
        .OFF_W (OFF_W)
    ) u_dec (
        .pte        (mem_rsp_data),
        .is_leaf    (is_leaf),
        .want_write (wr_q),
        .ppn        (dec_ppn),
        .code       (dec_code)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid)     state_nx = ST_L1_REQ;
            ST_L1_REQ:  if (mem_req_ready) state_nx = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid)
                            state_nx = (dec_code == FLT_NONE) ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  if (mem_req_ready) state_nx = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) state_nx = ST_DONE;
            ST_DONE:                       state_nx = ST_IDLE;
            default:                       state_nx = ST_IDLE;
        endcase
    end

    // Walk context registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            wr_q   <= 1'b0;
            base_q <= '0;
            code_q <= FLT_NONE;
            ppn_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    wr_q   <= req_write;
                    base_q <= req_ptbr;
                    code_q <= FLT_NONE;
                end
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    if (dec_code != FLT_NONE) code_q <= dec_code;
                    else                      base_q <= {dec_ppn, OFF_W'(0)};
                end
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    code_q <= dec_code;
                    ppn_q  <= dec_ppn;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy          = (state != ST_IDLE);
        done          = (state == ST_DONE);
        mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
        fault         = done && (code_q != FLT_NONE);
        fault_code    = done ? code_q : FLT_NONE;
        paddr         = (done && code_q == FLT_NONE) ? {ppn_q, va_q[OFF_W-1:0]} : '0;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int unsigned VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            done,
    input logic            fault,
    input logic [1:0]      fault_code,
    input logic [VA_W-1:0] paddr,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [VA_W-1:0] mem_req_addr
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    quiet_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!fault && fault_code == 2'd0 && paddr == '0));

    // R9
    fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (paddr == '0 && fault_code != 2'd0));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R2
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy ##1 !busy);

    // R2
    read_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (busy && !done));
endmodule

bind ptw_walker ptw_walker_chk #(.VA_W(VA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .busy          (busy),
    .done          (done),
    .fault         (fault),
    .fault_code    (fault_code),
    .paddr         (paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_ptbr = '0;
    logic        busy, done, fault;
    logic [1:0]  fault_code;
    logic [31:0] paddr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ptw_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_ptbr(req_ptbr), .busy(busy), .done(done),
        .fault(fault), .fault_code(fault_code), .paddr(paddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    // Memory model: small address/data table, configurable stall and latency
    logic [31:0] tbl_addr [8];
    logic [31:0] tbl_data [8];
    int          stall_cfg = 0;
    int          lat_cfg = 0;
    int          nreads = 0;
    logic [31:0] rd_log [4];
    bit          pend = 0;
    int          wcnt = 0;
    int          scnt = 0;
    logic [31:0] pend_addr = '0;

    function automatic logic [31:0] lookup(input logic [31:0] a);
        for (int i = 0; i < 8; i++) if (tbl_addr[i] == a) return tbl_data[i];
        return 32'h0;
    endfunction

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (wcnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = lookup(pend_addr);
                pend = 0;
            end else begin
                wcnt--;
            end
        end
        if (mem_req_valid && !pend && !mem_rsp_valid) begin
            if (scnt == 0) begin
                mem_req_ready = 1'b1;
                pend = 1;
                pend_addr = mem_req_addr;
                wcnt = lat_cfg;
                if (nreads < 4) rd_log[nreads] = mem_req_addr;
                nreads++;
                scnt = stall_cfg;
            end else begin
                mem_req_ready = 1'b0;
                scnt--;
            end
        end else begin
            mem_req_ready = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_walk(input string req, input logic [31:0] va, input logic wr,
                           input logic [31:0] base, input logic [1:0] ecode,
                           input logic [31:0] epa, input int ereads,
                           input logic [31:0] ea1, input logic [31:0] ea2,
                           input int junk_cycles);
        int t;
        nreads = 0;
        scnt = stall_cfg;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_ptbr = base;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R2", "busy after accept", 32'(busy), 32'd1);
        for (int k = 0; k < junk_cycles; k++) begin
            req_valid = 1'b1; req_vaddr = 32'hDEAD_BEEF; req_write = 1'b1;
            req_ptbr = 32'h0050_0000;
            @(negedge clk);
        end
        req_valid = 1'b0;
        t = 0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, req, "done seen", 32'(done), 32'd1);
        chk(fault == (ecode != 2'd0), req, "fault", 32'(fault), 32'(ecode != 2'd0));
        chk(fault_code == ecode, req, "fault_code", 32'(fault_code), 32'(ecode));
        chk(paddr == epa, req, "paddr", paddr, epa);
        chk(nreads == ereads, req, "read count", 32'(nreads), 32'(ereads));
        chk(rd_log[0] == ea1, "R3", "root entry address", rd_log[0], ea1);
        if (ereads > 1) chk(rd_log[1] == ea2, "R4", "leaf entry address", rd_log[1], ea2);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done one cycle", 32'(done), 32'd0);
        chk(busy == 1'b0, "R2", "idle after done", 32'(busy), 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy at reset", 32'(busy), 32'd0);
        chk(done == 1'b0, "R1", "done at reset", 32'(done), 32'd0);
        chk(fault == 1'b0, "R1", "fault at reset", 32'(fault), 32'd0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid at reset", 32'(mem_req_valid), 32'd0);
    endtask

    task automatic t_read_ok;
        do_walk("R5", 32'h0040_3ABC, 1'b0, 32'h0001_0000, 2'd0, 32'h0ABC_DABC, 2,
                32'h0001_0004, 32'h0002_000C, 0);
    endtask

    task automatic t_write_ok;
        do_walk("R5", 32'h0040_3ABC, 1'b1, 32'h0001_0000, 2'd0, 32'h0ABC_DABC, 2,
                32'h0001_0004, 32'h0002_000C, 0);
    endtask

    task automatic t_root_invalid;
        do_walk("R6", 32'h0080_0000, 1'b0, 32'h0001_0000, 2'd1, 32'h0, 1,
                32'h0001_0008, 32'h0, 0);
    endtask

    task automatic t_leaf_invalid;
        // leaf entry invalid and read-only: write still reports invalid (R7 priority)
        do_walk("R7", 32'h0040_4000, 1'b1, 32'h0001_0000, 2'd2, 32'h0, 2,
                32'h0001_0004, 32'h0002_0010, 0);
    endtask

    task automatic t_write_prot;
        do_walk("R8", 32'h0040_5123, 1'b1, 32'h0001_0000, 2'd3, 32'h0, 2,
                32'h0001_0004, 32'h0002_0014, 0);
        do_walk("R8", 32'h0040_5123, 1'b0, 32'h0001_0000, 2'd0, 32'h0007_7123, 2,
                32'h0001_0004, 32'h0002_0014, 0);
    endtask

    task automatic t_slow_memory;
        stall_cfg = 3; lat_cfg = 6;
        do_walk("R10", 32'h0040_3ABC, 1'b0, 32'h0001_0000, 2'd0, 32'h0ABC_DABC, 2,
                32'h0001_0004, 32'h0002_000C, 5);
        stall_cfg = 0; lat_cfg = 0;
    endtask

    task automatic t_index_top;
        do_walk("R5", 32'hFFFF_FFFF, 1'b1, 32'h0001_0000, 2'd0, 32'hFFFF_FFFF, 2,
                32'h0001_0FFC, 32'h0003_0FFC, 0);
    endtask

    initial begin
        tbl_addr[0] = 32'h0001_0004; tbl_data[0] = 32'h0002_0001;
        tbl_addr[1] = 32'h0002_000C; tbl_data[1] = 32'h0ABC_D003;
        tbl_addr[2] = 32'h0001_0008; tbl_data[2] = 32'h0003_0002;
        tbl_addr[3] = 32'h0002_0010; tbl_data[3] = 32'h0005_5000;
        tbl_addr[4] = 32'h0002_0014; tbl_data[4] = 32'h0007_7001;
        tbl_addr[5] = 32'h0001_0FFC; tbl_data[5] = 32'h0003_0001;
        tbl_addr[6] = 32'h0003_0FFC; tbl_data[6] = 32'hFFFF_F003;
        tbl_addr[7] = 32'hFFFF_FFF0; tbl_data[7] = 32'h0;
        for (int i = 0; i < 4; i++) rd_log[i] = '0;

        t_reset();
        t_read_ok();
        t_write_ok();
        t_root_invalid();
        t_leaf_invalid();
        t_write_prot();
        t_slow_memory();
        t_index_top();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule